// File: doc/BRIEF.md
# Dual-Width Inter-Processor Mailbox

This block is a small register bank shared by two processors that pass commands to each other. A host processor reaches it through a 16-bit register port. A satellite processor reaches it through a 32-bit register port. Both ports see the same five 32-bit mailbox registers: command, offset, parameter-low, parameter-high and status. The status register drives two level interrupt lines. Bit 0 controls the interrupt toward the satellite and bit 8 controls the interrupt toward the host. Each of these bits is active low: a 0 raises the line and a 1 lowers it.

The satellite port has some extra registers of its own. It has a 32-bit scratch word, a read-only identification word, and a 64-bit key word that is written and read as two 32-bit halves. Both ports are plain register ports. A write is a single cycle with select and write both high, and it takes effect at that clock edge. Read data is a combinational function of the address, so the port has no handshake and no back-pressure. The upstream bus adapter owns any valid/ready flow control.

Top module: `mbx_dual_port`

## Requirements
- R1: After reset, all five mailbox registers hold 0x0000FFFF, the scratch and key words hold 0, and both interrupt outputs are low.
- R2: On the host port, the mailbox registers are at byte addresses 0x3C (command), 0x40 (offset), 0x44 (parameter-low), 0x48 (parameter-high) and 0x4C (status). A host read returns bits 15:0 of the addressed register.
- R3: A host write replaces the whole 32-bit register with the 16-bit write value, zero-extended.
- R4: On the satellite port, the same registers are at 0x14, 0x18, 0x1C, 0x20 and 0x24, with full 32-bit reads and writes.
- R5: After a status write from either port, irq_to_sat is high when status bit 0 is 0 and low when it is 1.
- R6: After a status write from either port, irq_to_host is high when status bit 8 is 0 and low when it is 1.
- R7: Both interrupt outputs are registered. They change at the clock edge that captures a status write, not before it. Writes to any other register leave them unchanged.
- R8: Satellite address 0x00 is a 32-bit read/write scratch register.
- R9: Satellite address 0x2C always reads 0x0000000C, and writes to it have no effect.
- R10: The key is written and read as bits 31:0 at satellite address 0x30 and bits 63:32 at 0x34. A write to one half leaves the other half unchanged.
- R11: Reads of unmapped addresses return all ones (0xFFFFFFFF on the satellite port, 0xFFFF on the host port). Writes to unmapped addresses change no register.
- R12: If both ports write the same register in the same cycle, the satellite value is stored and the interrupts follow it. Writes from the two ports to different registers in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host port access select |
| h_wr | input | 1 | Host write strobe (used together with h_sel) |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data (combinational) |
| s_sel | input | 1 | Satellite port access select |
| s_wr | input | 1 | Satellite write strobe (used together with s_sel) |
| s_addr | input | 8 | Satellite byte address |
| s_wdata | input | 32 | Satellite write data |
| s_rdata | output | 32 | Satellite read data (combinational) |
| irq_to_sat | output | 1 | Level interrupt to the satellite |
| irq_to_host | output | 1 | Level interrupt to the host |

## Verification
The bench targets four corner cases.

- Zero extension of host writes. It reads the register back over the 32-bit port after the satellite has filled the upper half. A design that merged only the low half would leave stale upper bits.
- Interrupt timing and polarity. It samples the interrupts just before and just after the capturing edge, and checks each status bit in both states. An inverted or combinational interrupt would show up there.
- Same-cycle conflicts. It drives both ports at one register, including status, with values that raise opposite interrupt levels. A design that let the host win would assert both interrupts.
- Independent key halves and unmapped addresses. It also checks that unmapped reads return all ones and that writes there are dropped. A shared decode bug would corrupt a neighbouring register.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NSHR        = 5;
  localparam int HDW         = 16;
  localparam int SDW         = 32;
  localparam int KEYW        = 64;
  localparam int IDX_CMD     = 0;
  localparam int IDX_OFS     = 1;
  localparam int IDX_PRML    = 2;
  localparam int IDX_PRMH    = 3;
  localparam int IDX_STAT    = 4;
  localparam int STRIDE      = 4;
  localparam int HOST_BASE   = 'h3C;
  localparam int SAT_BASE    = 'h14;
  localparam int SAT_SCRATCH = 'h00;
  localparam int SAT_IDENT   = 'h2C;
  localparam int SAT_KEY_LO  = 'h30;
  localparam int SAT_KEY_HI  = 'h34;
  localparam logic [SDW-1:0] SHR_RST   = 32'h0000_FFFF;
  localparam logic [SDW-1:0] IDENT_VAL = 32'h0000_000C;
endpackage

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                      sel,
  input  logic                      wr,
  input  logic [AW-1:0]             addr,
  input  logic [NSHR-1:0][HDW-1:0]  shr_lo,
  output logic [NSHR-1:0]           wstb,
  output logic [HDW-1:0]            rdata
);
  logic [NSHR-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NSHR; gi++) begin : g_dec
      assign hit[gi]  = (addr == AW'(HOST_BASE + STRIDE * gi));
      assign wstb[gi] = sel & wr & hit[gi];
    end
  endgenerate

  always_comb begin
    rdata = '1;
    for (int i = 0; i < NSHR; i++) begin
      if (hit[i]) rdata = shr_lo[i];
    end
  end
endmodule

// File: rtl/mbx_sat_port.sv
module mbx_sat_port
  import mbx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic                      wr,
  input  logic [AW-1:0]             addr,
  input  logic [SDW-1:0]            wdata,
  input  logic [NSHR-1:0][SDW-1:0]  shr,
  output logic [NSHR-1:0]           wstb,
  output logic [SDW-1:0]            rdata
);
  localparam int HALF = KEYW / 2;

  logic [NSHR-1:0] hit;
  logic            hit_scr, hit_id, hit_klo, hit_khi;
  logic            we;
  logic [SDW-1:0]  scr_q;
  logic [KEYW-1:0] key_q;

  assign we = sel & wr;

  genvar gi;
  generate
    for (gi = 0; gi < NSHR; gi++) begin : g_dec
      assign hit[gi]  = (addr == AW'(SAT_BASE + STRIDE * gi));
      assign wstb[gi] = we & hit[gi];
    end
  endgenerate

  assign hit_scr = (addr == AW'(SAT_SCRATCH));
  assign hit_id  = (addr == AW'(SAT_IDENT));
  assign hit_klo = (addr == AW'(SAT_KEY_LO));
  assign hit_khi = (addr == AW'(SAT_KEY_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q <= '0;
    end else if (we && hit_scr) begin
      scr_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else begin
      if (we && hit_klo) key_q[HALF-1:0]    <= wdata;
      if (we && hit_khi) key_q[KEYW-1:HALF] <= wdata;
    end
  end

  always_comb begin
    rdata = '1;
    for (int i = 0; i < NSHR; i++) begin
      if (hit[i]) rdata = shr[i];
    end
    if (hit_scr) rdata = scr_q;
    if (hit_id)  rdata = IDENT_VAL;
    if (hit_klo) rdata = key_q[HALF-1:0];
    if (hit_khi) rdata = key_q[KEYW-1:HALF];
  end
endmodule

// File: rtl/mbx_shared_regs.sv
module mbx_shared_regs
  import mbx_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSHR-1:0]           h_wstb,
  input  logic [HDW-1:0]            h_wdata,
  input  logic [NSHR-1:0]           s_wstb,
  input  logic [SDW-1:0]            s_wdata,
  output logic [NSHR-1:0][SDW-1:0]  regs_q,
  output logic                      stat_we,
  output logic [SDW-1:0]            stat_nx
);
  logic [SDW-1:0] h_ext;
  assign h_ext = {{(SDW-HDW){1'b0}}, h_wdata};

  genvar gi;
  generate
    for (gi = 0; gi < NSHR; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_q[gi] <= SHR_RST;
        end else if (s_wstb[gi]) begin
          regs_q[gi] <= s_wdata;
        end else if (h_wstb[gi]) begin
          regs_q[gi] <= h_ext;
        end
      end
    end
  endgenerate

  assign stat_we = s_wstb[IDX_STAT] | h_wstb[IDX_STAT];
  assign stat_nx = s_wstb[IDX_STAT] ? s_wdata : h_ext;
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen
  import mbx_pkg::*;
#(
  parameter int SAT_BIT  = 0,
  parameter int HOST_BIT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stat_we,
  input  logic [SDW-1:0] stat_nx,
  output logic           irq_sat,
  output logic           irq_host
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sat  <= ~SHR_RST[SAT_BIT];
      irq_host <= ~SHR_RST[HOST_BIT];
    end else if (stat_we) begin
      irq_sat  <= ~stat_nx[SAT_BIT];
      irq_host <= ~stat_nx[HOST_BIT];
    end
  end
endmodule

// File: rtl/mbx_dual_port.sv
module mbx_dual_port
  import mbx_pkg::*;
#(
  parameter int AW       = 8,
  parameter int SAT_BIT  = 0,
  parameter int HOST_BIT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_sel,
  input  logic           h_wr,
  input  logic [AW-1:0]  h_addr,
  input  logic [HDW-1:0] h_wdata,
  output logic [HDW-1:0] h_rdata,
  input  logic           s_sel,
  input  logic           s_wr,
  input  logic [AW-1:0]  s_addr,
  input  logic [SDW-1:0] s_wdata,
  output logic [SDW-1:0] s_rdata,
  output logic           irq_to_sat,
  output logic           irq_to_host
);
  logic [NSHR-1:0][SDW-1:0] shr_q;
  logic [NSHR-1:0][HDW-1:0] shr_lo;
  logic [NSHR-1:0]          h_wstb, s_wstb;
  logic                     stat_we;
  logic [SDW-1:0]           stat_nx;
  logic [SDW-1:0]           stat_q;

  genvar gi;
  generate
    for (gi = 0; gi < NSHR; gi++) begin : g_lo
      assign shr_lo[gi] = shr_q[gi][HDW-1:0];
    end
  endgenerate

  assign stat_q = shr_q[IDX_STAT];

  mbx_host_port #(.AW(AW)) u_host (
    .sel(h_sel), .wr(h_wr), .addr(h_addr), .shr_lo(shr_lo),
    .wstb(h_wstb), .rdata(h_rdata)
  );

  mbx_sat_port #(.AW(AW)) u_sat (
    .clk(clk), .rst_n(rst_n), .sel(s_sel), .wr(s_wr), .addr(s_addr),
    .wdata(s_wdata), .shr(shr_q), .wstb(s_wstb), .rdata(s_rdata)
  );

  mbx_shared_regs u_regs (
    .clk(clk), .rst_n(rst_n), .h_wstb(h_wstb), .h_wdata(h_wdata),
    .s_wstb(s_wstb), .s_wdata(s_wdata), .regs_q(shr_q),
    .stat_we(stat_we), .stat_nx(stat_nx)
  );

  mbx_irq_gen #(.SAT_BIT(SAT_BIT), .HOST_BIT(HOST_BIT)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_nx(stat_nx),
    .irq_sat(irq_to_sat), .irq_host(irq_to_host)
  );
endmodule

// File: rtl/mbx_dual_port_chk.sv
module mbx_dual_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_sel,
  input logic        h_wr,
  input logic [7:0]  h_addr,
  input logic [15:0] h_wdata,
  input logic        s_sel,
  input logic        s_wr,
  input logic [7:0]  s_addr,
  input logic [31:0] s_wdata,
  input logic [31:0] s_rdata,
  input logic        irq_to_sat,
  input logic        irq_to_host,
  input logic [31:0] stat
);
  logic h_stw, s_stw, s_mapped;
  assign h_stw = h_sel & h_wr & (h_addr == 8'h4C);
  assign s_stw = s_sel & s_wr & (s_addr == 8'h24);
  assign s_mapped = (s_addr == 8'h00) || (s_addr == 8'h14) || (s_addr == 8'h18) ||
                    (s_addr == 8'h1C) || (s_addr == 8'h20) || (s_addr == 8'h24) ||
                    (s_addr == 8'h2C) || (s_addr == 8'h30) || (s_addr == 8'h34);

  a_r5_sat_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_sat == ~stat[0]);

  a_r6_host_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_host == ~stat[8]);

  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_stw || s_stw) |=> ($stable(irq_to_sat) && $stable(irq_to_host)));

  a_r3_host_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (h_stw && !s_stw) |=> stat == {16'h0000, $past(h_wdata)});

  a_r12_sat_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (h_stw && s_stw) |=> stat == $past(s_wdata));

  a_r9_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (s_addr == 8'h2C) |-> s_rdata == 32'h0000_000C);

  a_r11_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !s_mapped |-> s_rdata == 32'hFFFF_FFFF);
endmodule

bind mbx_dual_port mbx_dual_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
  .h_wdata(h_wdata), .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr),
  .s_wdata(s_wdata), .s_rdata(s_rdata), .irq_to_sat(irq_to_sat),
  .irq_to_host(irq_to_host), .stat(stat_q)
);

// File: tb/sim_mbx_dual_port.sv
module sim_mbx_dual_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 1'b0, h_wr = 1'b0;
  logic [7:0]  h_addr = 8'h00;
  logic [15:0] h_wdata = 16'h0;
  logic [15:0] h_rdata;
  logic        s_sel = 1'b0, s_wr = 1'b0;
  logic [7:0]  s_addr = 8'h00;
  logic [31:0] s_wdata = 32'h0;
  logic [31:0] s_rdata;
  logic        irq_to_sat, irq_to_host;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;   // 0 host read, 1 sat read, 2 irq pair {sat,host} in bits 1:0
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  mbx_dual_port u0 (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .s_sel(s_sel), .s_wr(s_wr),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .irq_to_sat(irq_to_sat), .irq_to_host(irq_to_host)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations and compares against live outputs
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        case (it.kind)
          0: chk(h_rdata == it.exp[15:0], it.tag, {16'h0, h_rdata}, {16'h0, it.exp[15:0]});
          1: chk(s_rdata == it.exp, it.tag, s_rdata, it.exp);
          default: chk({irq_to_sat, irq_to_host} == it.exp[1:0], it.tag,
                       {30'h0, irq_to_sat, irq_to_host}, {30'h0, it.exp[1:0]});
        endcase
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic hwr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    h_sel = 1'b1; h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_sel = 1'b0; h_wr = 1'b0;
  endtask

  task automatic swr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    s_sel = 1'b1; s_wr = 1'b1; s_addr = a; s_wdata = d;
    @(negedge clk);
    s_sel = 1'b0; s_wr = 1'b0;
  endtask

  task automatic bothwr(logic [7:0] ha, logic [15:0] hd, logic [7:0] sa, logic [31:0] sd);
    @(negedge clk);
    h_sel = 1'b1; h_wr = 1'b1; h_addr = ha; h_wdata = hd;
    s_sel = 1'b1; s_wr = 1'b1; s_addr = sa; s_wdata = sd;
    @(negedge clk);
    h_sel = 1'b0; h_wr = 1'b0; s_sel = 1'b0; s_wr = 1'b0;
  endtask

  task automatic hrd(logic [7:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    h_addr = a;
    push(0, {16'h0, e}, tag);
    @(negedge clk);
  endtask

  task automatic srd(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    s_addr = a;
    push(1, e, tag);
    @(negedge clk);
  endtask

  task automatic irqchk(bit es, bit eh, string tag);
    @(negedge clk);
    push(2, {30'h0, es, eh}, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2/R4 map
    for (int i = 0; i < 5; i++) hrd(8'h3C + 8'(4 * i), 16'hFFFF, "R1 R2 host reset value");
    for (int i = 0; i < 5; i++) srd(8'h14 + 8'(4 * i), 32'h0000_FFFF, "R1 R4 sat reset value");
    srd(8'h00, 32'h0, "R1 scratch reset");
    srd(8'h30, 32'h0, "R1 key lo reset");
    srd(8'h34, 32'h0, "R1 key hi reset");
    irqchk(1'b0, 1'b0, "R1 irqs low after reset");

    // R3 zero extension, R2/R4 cross-port visibility
    hwr(8'h3C, 16'h1234);
    srd(8'h14, 32'h0000_1234, "R3 host write zero-extends cmd");
    swr(8'h14, 32'hDEAD_BEEF);
    hrd(8'h3C, 16'hBEEF, "R2 host reads low half");
    srd(8'h14, 32'hDEAD_BEEF, "R4 sat full width cmd");
    swr(8'h18, 32'hFFFF_0000);
    hwr(8'h40, 16'hA5A5);
    srd(8'h18, 32'h0000_A5A5, "R3 upper half cleared by host write");
    swr(8'h1C, 32'h1111_2222);
    swr(8'h20, 32'h3333_4444);
    hrd(8'h44, 16'h2222, "R2 param lo");
    hrd(8'h48, 16'h4444, "R2 param hi");
    srd(8'h1C, 32'h1111_2222, "R4 param lo");
    srd(8'h20, 32'h3333_4444, "R4 param hi");

    // R5/R6/R7 interrupts, with edge timing
    @(negedge clk);
    s_sel = 1'b1; s_wr = 1'b1; s_addr = 8'h24; s_wdata = 32'h0000_0100;
    #1;
    chk({irq_to_sat, irq_to_host} == 2'b00, "R7 irq unchanged before edge",
        {30'h0, irq_to_sat, irq_to_host}, 32'h0);
    @(posedge clk);
    #2;
    chk({irq_to_sat, irq_to_host} == 2'b10, "R7 irq updated at capture edge",
        {30'h0, irq_to_sat, irq_to_host}, 32'h2);
    @(negedge clk);
    s_sel = 1'b0; s_wr = 1'b0;
    irqchk(1'b1, 1'b0, "R5 sat irq on bit0=0, R6 host irq off on bit8=1");
    hwr(8'h4C, 16'h0001);
    irqchk(1'b0, 1'b1, "R5 sat irq off, R6 host irq on (host write)");
    hwr(8'h4C, 16'h0000);
    irqchk(1'b1, 1'b1, "R5 R6 both asserted");
    swr(8'h14, 32'h0000_0101);
    hwr(8'h40, 16'h0101);
    irqchk(1'b1, 1'b1, "R7 non-status writes leave irqs");
    swr(8'h24, 32'hFFFF_FFFF);
    irqchk(1'b0, 1'b0, "R5 R6 both deasserted");
    hrd(8'h4C, 16'hFFFF, "R2 status readback");

    // R8 scratch, R9 ident
    swr(8'h00, 32'hCAFE_F00D);
    srd(8'h00, 32'hCAFE_F00D, "R8 scratch readback");
    srd(8'h2C, 32'h0000_000C, "R9 ident value");
    swr(8'h2C, 32'h0);
    srd(8'h2C, 32'h0000_000C, "R9 ident ignores write");

    // R10 key halves
    swr(8'h30, 32'h0123_4567);
    srd(8'h34, 32'h0, "R10 hi untouched by lo write");
    srd(8'h30, 32'h0123_4567, "R10 lo readback");
    swr(8'h34, 32'h89AB_CDEF);
    srd(8'h30, 32'h0123_4567, "R10 lo untouched by hi write");
    srd(8'h34, 32'h89AB_CDEF, "R10 hi readback");

    // R11 unmapped
    srd(8'h04, 32'hFFFF_FFFF, "R11 sat unmapped 0x04");
    srd(8'h28, 32'hFFFF_FFFF, "R11 sat unmapped 0x28");
    srd(8'h38, 32'hFFFF_FFFF, "R11 sat unmapped 0x38");
    srd(8'h15, 32'hFFFF_FFFF, "R11 sat misaligned 0x15");
    hrd(8'h00, 16'hFFFF, "R11 host unmapped 0x00");
    hrd(8'h3E, 16'hFFFF, "R11 host misaligned 0x3E");
    swr(8'h28, 32'h0);
    hwr(8'h50, 16'h0000);
    srd(8'h14, 32'h0000_0101, "R11 unmapped writes drop (cmd)");
    srd(8'h18, 32'h0000_0101, "R11 unmapped writes drop (offset)");
    irqchk(1'b0, 1'b0, "R11 unmapped writes leave irqs");

    // R12 conflicts
    bothwr(8'h48, 16'h5555, 8'h20, 32'h6666_7777);
    srd(8'h20, 32'h6666_7777, "R12 sat wins same register");
    bothwr(8'h4C, 16'h0000, 8'h24, 32'h0000_0101);
    irqchk(1'b0, 1'b0, "R12 irqs follow sat status");
    srd(8'h24, 32'h0000_0101, "R12 sat status stored");
    bothwr(8'h3C, 16'h7777, 8'h18, 32'h8888_8888);
    srd(8'h14, 32'h0000_7777, "R12 host write to other reg taken");
    srd(8'h18, 32'h8888_8888, "R12 sat write to other reg taken");

    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule